// File: doc/BRIEF.md
# Receive Sample Queue with Overrun Discard

This block buffers audio or modem samples that arrive from a slow serial bit-clock domain and hands them to a much faster system-clock domain. Each sample enters through a single-cycle strobe in the bit-clock domain. The sample is latched into a holding register there. A toggle signal then carries the event across to the system clock through a two-flop synchronizer, and the system side writes the held word into a sixteen-entry queue.

The system side drains the queue one word per read strobe. A DMA request stays asserted while the queue holds at least half its capacity. A sample that arrives while the queue is full is thrown away without touching the stored data. The drop sets a sticky overrun flag, which software clears by writing one. The flag can also be routed to an interrupt line. For channels that carry only 16-bit samples, a narrow mode forces the upper half of every word that is read to zero.

The system clock must run at least four times as fast as the bit clock. Sample strobes must be separated by at least two bit-clock cycles.

Top module: `rx_capture_fifo`

## Requirements
- R1: After reset the queue is empty, `dmaReq`, `overrunFlag` and `irq` are low, and `rdData` is zero.
- R2: With `narrowMode` low, words are read out in the order in which their sample strobes occurred, with all 32 bits intact.
- R3: The queue stores sixteen samples without losing any of them.
- R4: `dmaReq` is high exactly when the queue holds eight or more entries.
- R5: A sample that arrives while sixteen entries are held is discarded, and the sixteen stored words read back unchanged.
- R6: A discard sets `overrunFlag`. The flag stays set through reads and later samples until an `overrunClr` pulse (write-one-to-clear) lowers it.
- R7: `irq` is high exactly when `overrunFlag` and `overrunIrqEn` are both high.
- R8: With `narrowMode` high, bits 31..16 of `rdData` read as zero and bits 15..0 carry the sample.
- R9: A read strobe on an empty queue returns zero in `rdData` and leaves the read position unchanged, so the next stored sample still reads out correctly.
- R10: Each `sampleValid` pulse in the bit-clock domain produces exactly one queue entry in the system domain, when strobes are at least two bit-clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock |
| bitRstN | input | 1 | Active-low reset, bit-clock domain |
| sampleValid | input | 1 | One-cycle strobe marking a completed sample |
| sampleData | input | 32 | Completed sample word |
| sysClk | input | 1 | System clock, at least four times bitClk |
| sysRstN | input | 1 | Active-low reset, system domain |
| rdEn | input | 1 | Read strobe, pops one word |
| narrowMode | input | 1 | 1 = 16-bit channel, upper half reads zero |
| rdData | output | 32 | Word read by the last read strobe (registered) |
| dmaReq | output | 1 | Queue holds eight or more entries |
| overrunClr | input | 1 | Write-one pulse clearing the overrun flag |
| overrunIrqEn | input | 1 | Interrupt enable for the overrun flag |
| overrunFlag | output | 1 | Sticky overrun status |
| irq | output | 1 | Overrun interrupt |

## Verification
The bench builds the block with its default parameters: sixteen entries, 32-bit words and a threshold of eight. A few dozen sample strobes are therefore enough to walk the queue through empty, threshold, full and overrun. The bit clock runs at five times the system period, so every sample goes through the real synchronizer path. Strobes sent at the minimum two-cycle spacing test the toggle handshake at its tightest.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // strobes issued by the control to the datapath, one system cycle each
  typedef struct packed {
    logic push;      // write held sample at write position
    logic pop;       // load read register from read position
    logic readZero;  // read of an empty queue: load zero
  } rxf_strobe_t;
endpackage

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int HALF = WIDTH / 2
) (
  input  logic             bitClk,
  input  logic             bitRstN,
  input  logic             sampleValid,
  input  logic [WIDTH-1:0] sampleData,
  output logic             reqToggle,
  input  logic             sysClk,
  input  logic             sysRstN,
  input  rxf_strobe_t      strobe,
  input  logic [AW-1:0]    wrPtr,
  input  logic [AW-1:0]    rdPtr,
  input  logic             narrowMode,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] holdReg;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] readMask;

  // bit-clock side: latch sample and flip the request toggle
  always_ff @(posedge bitClk or negedge bitRstN) begin
    if (!bitRstN) begin
      holdReg   <= '0;
      reqToggle <= 1'b0;
    end else if (sampleValid) begin
      holdReg   <= sampleData;
      reqToggle <= ~reqToggle;
    end
  end

  // storage: holdReg is stable for several system cycles around push
  always_ff @(posedge sysClk) begin
    if (strobe.push) mem[wrPtr] <= holdReg;
  end

  assign readMask = narrowMode ? {{(WIDTH-HALF){1'b0}}, {HALF{1'b1}}} : {WIDTH{1'b1}};

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN)             rdData <= '0;
    else if (strobe.pop)      rdData <= mem[rdPtr] & readMask;
    else if (strobe.readZero) rdData <= '0;
  end

  // R8
  narrow_upper_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (strobe.pop && narrowMode) |=> (rdData[WIDTH-1:HALF] == '0));

  // R9
  empty_read_zero_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    strobe.readZero |=> (rdData == '0));
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          sysClk,
  input  logic          sysRstN,
  input  logic          reqToggle,
  input  logic          rdEn,
  input  logic          overrunClr,
  input  logic          irqEn,
  output rxf_strobe_t   strobe,
  output logic [AW-1:0] wrPtr,
  output logic [AW-1:0] rdPtr,
  output logic          dmaReq,
  output logic          overrunFlag,
  output logic          irq
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] REQ_CNT  = CW'(THRESH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [2:0]    syncQ;
  logic          arrival, full, empty, drop;
  logic [CW-1:0] count;

  // two-flop synchronizer plus edge-detect stage
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) syncQ <= '0;
    else          syncQ <= {syncQ[1:0], reqToggle};
  end
  assign arrival = syncQ[2] ^ syncQ[1];

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign drop  = arrival & full;

  assign strobe.push     = arrival & ~full;
  assign strobe.pop      = rdEn & ~empty;
  assign strobe.readZero = rdEn & empty;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN)        overrunFlag <= 1'b0;
    else if (drop)       overrunFlag <= 1'b1;
    else if (overrunClr) overrunFlag <= 1'b0;
  end

  assign dmaReq = (count >= REQ_CNT);
  assign irq    = overrunFlag & irqEn;

  // R3
  count_bound_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    count <= FULL_CNT);

  // R5
  full_hold_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (arrival && full) |=> $stable(wrPtr));

  // R6
  drop_sets_flag_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    drop |=> overrunFlag);

  // R6
  flag_clear_only_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $fell(overrunFlag) |-> $past(overrunClr));

  // R9
  empty_ptr_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (rdEn && empty) |=> $stable(rdPtr));
endmodule

// File: rtl/rx_capture_fifo.sv
module rx_capture_fifo
  import rxf_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 16,
  parameter int THRESH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             bitClk,
  input  logic             bitRstN,
  input  logic             sampleValid,
  input  logic [WIDTH-1:0] sampleData,
  input  logic             sysClk,
  input  logic             sysRstN,
  input  logic             rdEn,
  input  logic             narrowMode,
  output logic [WIDTH-1:0] rdData,
  output logic             dmaReq,
  input  logic             overrunClr,
  input  logic             overrunIrqEn,
  output logic             overrunFlag,
  output logic             irq
);
  rxf_strobe_t   strobe;
  logic          reqToggle;
  logic [AW-1:0] wrPtr, rdPtr;

  rxf_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH)) u_ctrl (
    .sysClk(sysClk), .sysRstN(sysRstN), .reqToggle(reqToggle),
    .rdEn(rdEn), .overrunClr(overrunClr), .irqEn(overrunIrqEn),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .dmaReq(dmaReq), .overrunFlag(overrunFlag), .irq(irq)
  );

  rxf_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .bitClk(bitClk), .bitRstN(bitRstN), .sampleValid(sampleValid),
    .sampleData(sampleData), .reqToggle(reqToggle),
    .sysClk(sysClk), .sysRstN(sysRstN), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .narrowMode(narrowMode), .rdData(rdData)
  );
endmodule

// File: tb/rx_capture_fifo_tb.sv
module rx_capture_fifo_tb;
  logic        bitClk = 0, sysClk = 0;
  logic        bitRstN = 0, sysRstN = 0;
  logic        sampleValid = 0;
  logic [31:0] sampleData = '0;
  logic        rdEn = 0, narrowMode = 0, overrunClr = 0, overrunIrqEn = 0;
  logic [31:0] rdData;
  logic        dmaReq, overrunFlag, irq;
  int checks = 0, fails = 0;

  always #10 sysClk = ~sysClk;  // 50 MHz
  always #50 bitClk = ~bitClk;

  rx_capture_fifo u_dut (
    .bitClk(bitClk), .bitRstN(bitRstN), .sampleValid(sampleValid),
    .sampleData(sampleData), .sysClk(sysClk), .sysRstN(sysRstN),
    .rdEn(rdEn), .narrowMode(narrowMode), .rdData(rdData), .dmaReq(dmaReq),
    .overrunClr(overrunClr), .overrunIrqEn(overrunIrqEn),
    .overrunFlag(overrunFlag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendSample(input logic [31:0] d);
    @(negedge bitClk);
    sampleValid = 1; sampleData = d;
    @(negedge bitClk);
    sampleValid = 0;
    repeat (6) @(posedge sysClk);
    @(negedge sysClk);
  endtask

  task automatic readWord(output logic [31:0] d);
    @(negedge sysClk); rdEn = 1;
    @(negedge sysClk); rdEn = 0;
    d = rdData;
  endtask

  task automatic testReset();
    check("R1 rdData", rdData, 0);
    check("R1 dmaReq", {31'b0, dmaReq}, 0);
    check("R1 overrunFlag", {31'b0, overrunFlag}, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic testEmptyRead();
    logic [31:0] d;
    readWord(d);
    check("R9 empty read value", d, 0);
    sendSample(32'hA5A5_1234);
    readWord(d);
    check("R9 sample after empty read", d, 32'hA5A5_1234);
  endtask

  task automatic testOrderAndDma();
    logic [31:0] d;
    for (int i = 0; i < 7; i++) sendSample(32'h1000_0000 + i);
    check("R4 seven entries no request", {31'b0, dmaReq}, 0);
    sendSample(32'h1000_0007);
    check("R4 eight entries request", {31'b0, dmaReq}, 1);
    readWord(d);
    check("R2 first out", d, 32'h1000_0000);
    check("R4 seven after read", {31'b0, dmaReq}, 0);
    for (int i = 1; i < 8; i++) begin
      readWord(d);
      check("R2 order", d, 32'h1000_0000 + i);
    end
  endtask

  task automatic testOverrun();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) sendSample(32'hC0DE_0000 + i * 32'h0001_0101);
    check("R3 full no overrun", {31'b0, overrunFlag}, 0);
    check("R4 full request", {31'b0, dmaReq}, 1);
    sendSample(32'hDEAD_DEAD);
    check("R6 overrun set", {31'b0, overrunFlag}, 1);
    check("R7 irq masked", {31'b0, irq}, 0);
    @(negedge sysClk); overrunIrqEn = 1;
    @(negedge sysClk);
    check("R7 irq enabled", {31'b0, irq}, 1);
    for (int i = 0; i < 16; i++) begin
      readWord(d);
      check("R5 stored word kept", d, 32'hC0DE_0000 + i * 32'h0001_0101);
    end
    readWord(d);
    check("R5 dropped sample absent", d, 0);
    sendSample(32'h0000_0042);
    check("R6 flag sticky", {31'b0, overrunFlag}, 1);
    @(negedge sysClk); overrunClr = 1;
    @(negedge sysClk); overrunClr = 0;
    check("R6 flag cleared", {31'b0, overrunFlag}, 0);
    check("R7 irq low after clear", {31'b0, irq}, 0);
    readWord(d);
    check("R10 post-overrun sample", d, 32'h0000_0042);
    overrunIrqEn = 0;
  endtask

  task automatic testNarrow();
    logic [31:0] d;
    narrowMode = 1;
    sendSample(32'hDEAD_BEEF);
    readWord(d);
    check("R8 upper half zero", d, 32'h0000_BEEF);
    narrowMode = 0;
  endtask

  task automatic testTightSpacing();
    logic [31:0] d;
    @(negedge bitClk);
    for (int i = 0; i < 4; i++) begin
      sampleValid = 1; sampleData = 32'h7700_0000 + i;
      @(negedge bitClk); sampleValid = 0;
      @(negedge bitClk);
    end
    repeat (8) @(posedge sysClk);
    for (int i = 0; i < 4; i++) begin
      readWord(d);
      check("R10 tight spacing", d, 32'h7700_0000 + i);
    end
    readWord(d);
    check("R10 no extra entry", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge sysClk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge bitClk);
    bitRstN = 1; sysRstN = 1;
    @(negedge sysClk);
    testReset();
    testEmptyRead();
    testOrderAndDma();
    testOverrun();
    testNarrow();
    testTightSpacing();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule